// File: doc/BRIEF.md
# Four-Lane Parallel CRC16 Generator

This block computes the data checksum used on a four-line card data bus, where every data line carries its own CRC16. One nibble arrives per clock under a valid flag; bit i of the nibble belongs to line i. Four CRC16 registers advance together, one bit each per accepted nibble, using the polynomial x^16 + x^12 + x^5 + 1. They start from zero and have no final inversion. A clear strobe starts a new block. The feeder sends each data byte as two nibbles, the high nibble first.

The four checksums are available at all times as one 64-bit word. This word is interleaved by nibble, so nibble k holds bit k of every lane. On request, the block also drains the checksums as sixteen nibbles, most significant bit first, so a transmitter can append them after the data. The drain empties the registers.

On the receive side, the data nibbles are fed in, followed by the sixteen received checksum nibbles. For an intact block, every lane then reads zero and the match flag is high.

Top module: `quad_lane_crc16`

## Requirements
- R1: After reset, `crc_o` is zero, `crc_ok_o` is 1 and `ser_valid_o` is 0.
- R2: A sampled `clear_i` zeroes all four lane registers by the next cycle. It takes priority over `valid_i` and `shift_i`, and it aborts a drain in progress.
- R3: With `clear_i` low, `valid_i` low and no drain running, all lane registers keep their value, whatever `nib_i` carries.
- R4: Each accepted nibble advances lane i with bit i of `nib_i`, using x^16+x^12+x^5+1 (0x1021), zero start, no final inversion. The lanes are independent of each other. Feeding the bytes 0x31..0x39 as one bit per nibble on bit 0 (byte MSB first) leaves lane 0 at 0x31C3 and the other lanes at zero.
- R5: Bit 4k+i of `crc_o` equals bit k of lane i's CRC, for k = 0..15 and i = 0..3.
- R6: When `shift_i` is sampled while no drain is running, `ser_valid_o` is high for exactly the next 16 cycles. In drain cycle j (j = 0..15), bit i of `ser_nib_o` is bit 15-j of lane i's CRC as it stood when the drain began.
- R7: When a drain completes, all lane registers are zero.
- R8: While a drain runs, `valid_i`, `nib_i` and `shift_i` have no effect on the drained nibbles or on the final state.
- R9: `crc_ok_o` is 1 exactly when all four lanes are zero. When a block is fed in, followed by its 16 drained nibbles in drain order, the result is 1. A single flipped data bit makes the result 0.
- R10: A full 512-byte block (1024 nibbles) gives the same per-lane CRC as four independent serial CRC16 computations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Zero all lanes and abort a drain |
| valid_i | input | 1 | Accept `nib_i` this cycle |
| nib_i | input | 4 | One bit per data line |
| shift_i | input | 1 | Start a 16-cycle drain of the checksums |
| crc_o | output | 64 | Interleaved checksums, nibble k = bit k of each lane |
| crc_ok_o | output | 1 | All lanes are zero |
| ser_valid_o | output | 1 | Drain nibble valid |
| ser_nib_o | output | 4 | Drained checksum nibble, MSB first per lane |

## Verification
The bench builds the block with its default parameters: four lanes of sixteen bits and a sixteen-beat drain. At this size, every single nibble and every ordered pair of nibbles from a cleared state can be compared against an arithmetic per-lane model in the bench. A fixed known-answer string anchors that model. Full 1024-nibble blocks exercise the drain, the receive-side zero check and a single-bit corruption. Inputs are toggled during a drain, and a drain is aborted by clear, to reach the priority and ignore cases.

// File: rtl/quad_crc_pkg.sv
package quad_crc_pkg;

    // Operation applied to every lane register in a cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_STEP  = 2'd2,
        OP_SHIFT = 2'd3
    } lane_op_e;

endpackage

// File: rtl/crc_lane_reg.sv
module crc_lane_reg
    import quad_crc_pkg::*;
#(
    parameter int unsigned    W    = 16,
    parameter logic [W-1:0]   POLY = 16'h1021
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lane_op_e      op_i,
    input  logic          din_i,
    output logic [W-1:0]  crc_o
);

    typedef struct packed {
        logic [W-1:0] crc;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic        fb;

    always_comb begin
        st_d = st_q;
        fb   = st_q.crc[W-1] ^ din_i;
        unique case (op_i)
            OP_CLEAR: st_d.crc = '0;
            OP_STEP:  st_d.crc = {st_q.crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
            OP_SHIFT: st_d.crc = {st_q.crc[W-2:0], 1'b0};
            default:  st_d.crc = st_q.crc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_o = st_q.crc;

    // R2: a clear leaves the lane at zero
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_CLEAR |=> crc_o == '0);

    // R3: idle cycles keep the lane
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_HOLD |=> $stable(crc_o));

    // R7: draining fills with zeros from the bottom
    p_shift_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_SHIFT |=> crc_o[0] == 1'b0);

endmodule

// File: rtl/crc_drain_ctrl.sv
module crc_drain_ctrl #(
    parameter int unsigned BEATS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic                         shift_req_i,
    output logic                         busy_o,
    output logic [$clog2(BEATS)-1:0]     beat_o
);

    localparam int unsigned    CW   = $clog2(BEATS);
    localparam logic [CW-1:0]  LAST = CW'(BEATS - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } drain_state_t;

    drain_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (shift_req_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign beat_o = st_q.cnt;

    // R6: a request while idle opens a drain at beat zero
    p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && shift_req_i && !clear_i |=> busy_o && beat_o == '0);

    // R6: the drain closes after its last beat
    p_run_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && beat_o == LAST && !clear_i |=> !busy_o);

    // R8: a request during a drain does not restart the count
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && beat_o != LAST && !clear_i |=> busy_o && beat_o == $past(beat_o) + 1'b1);

    // R2: clear aborts a drain
    p_clear_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !busy_o);

endmodule

// File: rtl/quad_lane_crc16.sv
module quad_lane_crc16
    import quad_crc_pkg::*;
#(
    parameter int unsigned        LANES = 4,
    parameter int unsigned        CRC_W = 16,
    parameter logic [CRC_W-1:0]   POLY  = 16'h1021
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     valid_i,
    input  logic [LANES-1:0]         nib_i,
    input  logic                     shift_i,
    output logic [LANES*CRC_W-1:0]   crc_o,
    output logic                     crc_ok_o,
    output logic                     ser_valid_o,
    output logic [LANES-1:0]         ser_nib_o
);

    localparam int unsigned BEAT_W = $clog2(CRC_W);

    lane_op_e            op;
    logic                busy;
    logic [BEAT_W-1:0]   beat;
    logic [CRC_W-1:0]    lane_crc [LANES];

    // Priority: clear, then drain, then data
    always_comb begin
        if (clear_i) begin
            op = OP_CLEAR;
        end else if (busy) begin
            op = OP_SHIFT;
        end else if (valid_i) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

    crc_drain_ctrl #(
        .BEATS (CRC_W)
    ) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .shift_req_i (shift_i),
        .busy_o      (busy),
        .beat_o      (beat)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        crc_lane_reg #(
            .W    (CRC_W),
            .POLY (POLY)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .op_i  (op),
            .din_i (nib_i[i]),
            .crc_o (lane_crc[i])
        );

        assign ser_nib_o[i] = busy & lane_crc[i][CRC_W-1];

        for (genvar k = 0; k < CRC_W; k++) begin : g_bit
            assign crc_o[k*LANES + i] = lane_crc[i][k];
        end
    end

    assign ser_valid_o = busy;
    assign crc_ok_o    = ~|crc_o;

    // R7: a drain that ends on its own leaves every lane empty
    p_drain_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_valid_o) && !$past(clear_i) |-> crc_o == '0);

    // R6: drained nibbles are quiet outside a drain
    p_ser_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid_o |-> ser_nib_o == '0);

    // R6: beat counter runs only inside a drain
    p_beat_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid_o |-> beat == '0);

endmodule

// File: tb/test_quad_lane_crc16.sv
module test_quad_lane_crc16;

    localparam int LANES = 4;
    localparam int W     = 16;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 clear_i, valid_i, shift_i;
    logic [LANES-1:0]     nib_i;
    logic [LANES*W-1:0]   crc_o;
    logic                 crc_ok_o, ser_valid_o;
    logic [LANES-1:0]     ser_nib_o;

    always #5 clk = ~clk;

    quad_lane_crc16 i_quad_lane_crc16 (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .valid_i     (valid_i),
        .nib_i       (nib_i),
        .shift_i     (shift_i),
        .crc_o       (crc_o),
        .crc_ok_o    (crc_ok_o),
        .ser_valid_o (ser_valid_o),
        .ser_nib_o   (ser_nib_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [W-1:0]   mdl [LANES];
    logic [3:0]     blk [1024];
    logic [3:0]     cap [16];
    logic [7:0]     lfsr;

    function automatic logic [W-1:0] ref_step(input logic [W-1:0] c, input logic b);
        logic fb;
        fb = c[W-1] ^ b;
        c  = c << 1;
        if (fb) c = c ^ 16'h1021;
        return c;
    endfunction

    function automatic logic [LANES*W-1:0] pack_mdl();
        logic [LANES*W-1:0] r;
        r = '0;
        for (int k = 0; k < W; k++)
            for (int i = 0; i < LANES; i++)
                r[k*LANES + i] = mdl[i][k];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic clr, input logic v, input logic sh, input logic [3:0] n);
        clear_i = clr;
        valid_i = v;
        shift_i = sh;
        nib_i   = n;
        @(negedge clk);
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < LANES; i++) mdl[i] = '0;
        drive(1'b1, 1'b0, 1'b0, 4'h0);
    endtask

    task automatic feed(input logic [3:0] n);
        for (int i = 0; i < LANES; i++) mdl[i] = ref_step(mdl[i], n[i]);
        drive(1'b0, 1'b1, 1'b0, n);
    endtask

    task automatic next_byte(output logic [7:0] b);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        b = lfsr;
    endtask

    task automatic build_block();
        logic [7:0] b;
        for (int j = 0; j < 512; j++) begin
            next_byte(b);
            blk[2*j]     = b[7:4];
            blk[2*j + 1] = b[3:0];
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] kat [9];
        logic [3:0] exp_nib;

        rst_n   = 1'b0;
        clear_i = 1'b0;
        valid_i = 1'b0;
        shift_i = 1'b0;
        nib_i   = '0;
        lfsr    = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: state after reset
        check("R1 crc", crc_o, 64'h0);
        check("R1 ok", {63'h0, crc_ok_o}, 64'h1);
        check("R1 ser_valid", {63'h0, ser_valid_o}, 64'h0);

        // R5: one nibble 0x1 puts 0x1021 in lane 0 -> bits 0, 20, 48
        mdl_clear();
        feed(4'h1);
        check("R5 layout", crc_o, 64'h0001_0000_0010_0001);

        // R4/R5: every single nibble from a cleared state
        for (int v = 0; v < 16; v++) begin
            mdl_clear();
            feed(4'(v));
            check("R4 single nibble", crc_o, pack_mdl());
        end

        // R4: every ordered pair of nibbles
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                mdl_clear();
                feed(4'(a));
                feed(4'(b));
                check("R4 nibble pair", crc_o, pack_mdl());
            end
        end

        // R4: known answer on lane 0, other lanes untouched
        kat = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        mdl_clear();
        for (int j = 0; j < 9; j++)
            for (int t = 7; t >= 0; t--)
                feed({3'b000, kat[j][t]});
        begin
            logic [15:0] lane0, rest;
            lane0 = '0;
            rest  = '0;
            for (int k = 0; k < W; k++) begin
                lane0[k] = crc_o[k*LANES];
                rest[k]  = crc_o[k*LANES + 1] | crc_o[k*LANES + 2] | crc_o[k*LANES + 3];
            end
            check("R4 known answer lane0", {48'h0, lane0}, 64'h31C3);
            check("R4 known answer other lanes", {48'h0, rest}, 64'h0);
        end

        // R3: idle cycles hold, whatever nib_i carries
        for (int j = 0; j < 5; j++) drive(1'b0, 1'b0, 1'b0, 4'hF);
        check("R3 hold", crc_o, pack_mdl());

        // R2: clear wins over valid
        for (int i = 0; i < LANES; i++) mdl[i] = '0;
        drive(1'b1, 1'b1, 1'b0, 4'hF);
        check("R2 clear priority", crc_o, 64'h0);
        check("R9 ok after clear", {63'h0, crc_ok_o}, 64'h1);

        // R4: varied stream lengths
        for (int len = 1; len <= 40; len += 3) begin
            logic [7:0] b;
            mdl_clear();
            for (int j = 0; j < len; j++) begin
                next_byte(b);
                feed(b[3:0]);
            end
            check("R4 stream", crc_o, pack_mdl());
            check("R9 ok flag tracks zero", {63'h0, crc_ok_o}, {63'h0, (pack_mdl() == 64'h0)});
        end

        // R10: full block, then drain
        build_block();
        mdl_clear();
        for (int j = 0; j < 1024; j++) feed(blk[j]);
        check("R10 block crc", crc_o, pack_mdl());

        drive(1'b0, 1'b0, 1'b1, 4'h0);
        for (int j = 0; j < 16; j++) begin
            for (int i = 0; i < LANES; i++) exp_nib[i] = mdl[i][15-j];
            check("R6 drain valid", {63'h0, ser_valid_o}, 64'h1);
            check("R6 drain nibble", {60'h0, ser_nib_o}, {60'h0, exp_nib});
            cap[j] = ser_nib_o;
            // R8: inputs toggled during the drain
            drive(1'b0, j[0], (j % 3) == 0, 4'hF);
        end
        check("R6 drain ends", {63'h0, ser_valid_o}, 64'h0);
        check("R7 empty after drain", crc_o, 64'h0);
        check("R8 ignored inputs", {63'h0, crc_ok_o}, 64'h1);

        // R9: receive side, block plus its drained checksum
        mdl_clear();
        for (int j = 0; j < 1024; j++) feed(blk[j]);
        for (int j = 0; j < 16; j++) feed(cap[j]);
        check("R9 good block", {63'h0, crc_ok_o}, 64'h1);

        // R9: one flipped data bit
        mdl_clear();
        for (int j = 0; j < 1024; j++) feed((j == 300) ? (blk[j] ^ 4'h4) : blk[j]);
        for (int j = 0; j < 16; j++) feed(cap[j]);
        check("R9 corrupted block", {63'h0, crc_ok_o}, 64'h0);
        check("R9 corrupted crc model", crc_o, pack_mdl());

        // R2: clear aborts a running drain
        mdl_clear();
        feed(4'hA);
        feed(4'h5);
        drive(1'b0, 1'b0, 1'b1, 4'h0);
        drive(1'b0, 1'b0, 1'b0, 4'h0);
        drive(1'b0, 1'b0, 1'b0, 4'h0);
        drive(1'b1, 1'b0, 1'b0, 4'h0);
        check("R2 abort ser_valid", {63'h0, ser_valid_o}, 64'h0);
        check("R2 abort crc", crc_o, 64'h0);

        // R6: a new drain after abort starts cleanly from new data
        for (int i = 0; i < LANES; i++) mdl[i] = '0;
        feed(4'h9);
        drive(1'b0, 1'b0, 1'b1, 4'h0);
        for (int j = 0; j < 16; j++) begin
            for (int i = 0; i < LANES; i++) exp_nib[i] = mdl[i][15-j];
            check("R6 second drain nibble", {60'h0, ser_nib_o}, {60'h0, exp_nib});
            drive(1'b0, 1'b0, 1'b0, 4'h0);
        end
        check("R7 second drain empty", crc_o, 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule